// File: doc/BRIEF.md
# PHY Interrupt Status Aggregator

This block holds the interrupt side of an Ethernet PHY's management register space. A 16-bit enable register and a 16-bit status register sit behind a simple register port. Single-cycle event strobes from the PHY core set the matching status bits, and the bits stay latched until software reads the status register. That read returns the latched events and clears them in the same cycle.

From the two registers the block drives one registered, active-high interrupt line. Bit 15 of the enable register is a global switch over that line. It also drives a two-bit cause summary. The link-change class covers link change and both autonegotiation results. The FIFO-error class covers transmit and receive FIFO faults. A host interrupt handler can sort an interrupt from these two bits without decoding every event.

Top module: `phy_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, both registers hold 0 and `irq`, `cause_out` and `reg_rdata` are 0.
- R2: A write to address 25 stores the written value masked to bits 0-8, 10, 11, 13 and 15 into the enable register. A later read of address 25 returns that masked value.
- R3: A strobe on `evt_strobe[i]` sets status bit i at the next clock edge, for i in 0-8, 10, 11 and 13. Strobes on bits 9, 12, 14 and 15 are ignored, and those status bits always read 0.
- R4: A read (`reg_rd` high) loads `reg_rdata` at the next edge, and `reg_rdata` then holds until the next read. A read of address 26 returns the status as it stood before the edge and clears every status bit.
- R5: An event strobe in the same cycle as a status read is not lost. Its bit is set after the clear, and the next status read returns it.
- R6: `irq` is registered: one edge after the registers settle, it equals enable bit 15 AND the OR of (status AND enable) over bits 0-13.
- R7: `cause_out[0]` (link change) is the OR of (status AND enable) over bits 13, 11 and 10. `cause_out[1]` (FIFO error) is the same over bits 5 and 6. Both are registered with the same timing as `irq` and do not depend on enable bit 15.
- R8: Writes to address 26 or to any address other than 25 change nothing. Reads of any address other than 25 and 26, including 28, return 0.
- R9: Writing 0 to address 25 clears the whole enable register, so `irq` and both cause bits are 0 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data, held between reads |
| evt_strobe | input | 16 | Single-cycle event pulses, one per status bit |
| irq | output | 1 | Registered interrupt request, active high |
| cause_out | output | 2 | Bit 0: link-change class, bit 1: FIFO-error class |

## Verification
A status read and a fresh event strobe can land in the same cycle. The clear must not erase the new event. The bench provokes this by pulsing an event together with a read of address 26. It then judges two things: the read returns only the older events, and a second read returns the new one. A cycle-by-cycle behavioural model is compared against every output on every clock. Random mixes of reads, writes and strobes add many more of these collisions.

// File: rtl/phy_irq_pkg.sv
// Package: register addresses, bit positions and derived masks shared by
// the interrupt aggregator modules.
package phy_irq_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 5'd25;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 5'd26;

    // Event bit positions that the cause decode depends on
    localparam int BIT_RX_FIFO  = 5;
    localparam int BIT_TX_FIFO  = 6;
    localparam int BIT_AN_DONE  = 10;
    localparam int BIT_AN_FAIL  = 11;
    localparam int BIT_LINK     = 13;
    localparam int BIT_GLOBAL   = 15;
    localparam int IRQ_SRC_BITS = 14;

    localparam logic [REG_W-1:0] LINK_GRP_MASK =
        (16'd1 << BIT_LINK) | (16'd1 << BIT_AN_FAIL) | (16'd1 << BIT_AN_DONE);
    localparam logic [REG_W-1:0] FIFO_GRP_MASK =
        (16'd1 << BIT_RX_FIFO) | (16'd1 << BIT_TX_FIFO);
    // Bits 0..8 are plain events; 9, 12, 14 are reserved
    localparam logic [REG_W-1:0] LOW_EVT_MASK  = 16'h01FF;
    localparam logic [REG_W-1:0] STATUS_MASK   =
        LOW_EVT_MASK | LINK_GRP_MASK | FIFO_GRP_MASK;
    localparam logic [REG_W-1:0] ENABLE_MASK   =
        STATUS_MASK | (16'd1 << BIT_GLOBAL);
    localparam logic [REG_W-1:0] IRQ_SRC_MASK  = (16'd1 << IRQ_SRC_BITS) - 16'd1;

    typedef struct packed {
        logic fifo;
        logic link;
    } cause_t;
endpackage

// File: rtl/phy_irq_enable.sv
// Enable register. Holds the per-event enables and the global enable bit.
// Assumes writes are single-cycle strobes; unimplemented bits stay 0.
module phy_irq_enable
    import phy_irq_pkg::*;
#(
    parameter int W = REG_W,
    parameter int A = ADDR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [A-1:0] addr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_q
);
    logic hit_w;
    assign hit_w = wr_i && (addr_i == ADDR_ENABLE);

    // Load masked write data on an addressed write
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (hit_w) en_q <= wdata_i & ENABLE_MASK;
    end

    AST_ZERO_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_w && wdata_i == '0) |=> (en_q == '0)); // R9
endmodule

// File: rtl/phy_irq_status.sv
// Status register. Latches event strobes and clears on a status read.
// Assumes strobes last one cycle; a strobe coinciding with the clear wins.
module phy_irq_status
    import phy_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] evt_i,
    output logic [W-1:0] st_q
);
    logic [W-1:0] evt_m;
    logic [W-1:0] keep_w;
    assign evt_m  = evt_i & STATUS_MASK;
    assign keep_w = clr_i ? '0 : st_q;

    // Clear on read, then OR in new events so none is lost
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= keep_w | evt_m;
    end

    AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_m != '0) |=> ((st_q & $past(evt_m)) == $past(evt_m))); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_m == '0) |=> (st_q == '0)); // R4
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & ~STATUS_MASK) == '0)); // R3
endmodule

// File: rtl/phy_irq_cause.sv
// Interrupt and cause decode. Registers the gated interrupt and the two
// cause classes from the current status and enable registers.
module phy_irq_cause
    import phy_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] st_i,
    input  logic [W-1:0] en_i,
    output logic         irq_q,
    output cause_t       cause_q
);
    logic [W-1:0] act_w;
    cause_t       cause_d;
    assign act_w        = st_i & en_i;
    assign cause_d.link = |(act_w & LINK_GRP_MASK);
    assign cause_d.fifo = |(act_w & FIFO_GRP_MASK);

    // Register interrupt (globally gated) and the ungated cause classes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            cause_q <= '0;
        end else begin
            irq_q   <= en_i[BIT_GLOBAL] && |(act_w & IRQ_SRC_MASK);
            cause_q <= cause_d;
        end
    end

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i[BIT_GLOBAL] |=> !irq_q); // R6
    AST_LINK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_i & LINK_GRP_MASK) == '0) |=> !cause_q.link); // R7
    AST_FIFO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_i & FIFO_GRP_MASK) == '0) |=> !cause_q.fifo); // R7
endmodule

// File: rtl/phy_irq_readport.sv
// Read port. Captures the addressed register on a read strobe and holds it.
// Unmapped addresses return 0.
module phy_irq_readport
    import phy_irq_pkg::*;
#(
    parameter int W = REG_W,
    parameter int A = ADDR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_i,
    input  logic [A-1:0] addr_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] st_i,
    output logic [W-1:0] rdata_q
);
    logic [W-1:0] mux_w;

    // Select register contents by address
    always_comb begin
        case (addr_i)
            ADDR_ENABLE: mux_w = en_i;
            ADDR_STATUS: mux_w = st_i;
            default:     mux_w = '0;
        endcase
    end

    // Capture selected value on a read, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= mux_w;
    end

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_q)); // R4
endmodule

// File: rtl/phy_irq_agg.sv
// Top: PHY interrupt status aggregator. Ties the enable register, status
// register, interrupt/cause decode and read port together.
module phy_irq_agg
    import phy_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [REG_W-1:0]  evt_strobe,
    output logic              irq,
    output logic [1:0]        cause_out
);
    logic [REG_W-1:0] en_w;
    logic [REG_W-1:0] st_w;
    logic             clr_w;
    cause_t           cause_w;

    assign clr_w     = reg_rd && (reg_addr == ADDR_STATUS);
    assign cause_out = cause_w;

    phy_irq_enable #(.W(REG_W), .A(ADDR_W)) u_enable (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .en_q(en_w));

    phy_irq_status #(.W(REG_W)) u_status (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_w), .evt_i(evt_strobe),
        .st_q(st_w));

    phy_irq_cause #(.W(REG_W)) u_cause (
        .clk(clk), .rst_n(rst_n), .st_i(st_w), .en_i(en_w),
        .irq_q(irq), .cause_q(cause_w));

    phy_irq_readport #(.W(REG_W), .A(ADDR_W)) u_read (
        .clk(clk), .rst_n(rst_n), .rd_i(reg_rd), .addr_i(reg_addr),
        .en_i(en_w), .st_i(st_w), .rdata_q(reg_rdata));
endmodule

// File: tb/test_phy_irq_agg.sv
module test_phy_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic [15:0] evt_strobe = '0;
    logic        irq;
    logic [1:0]  cause_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    phy_irq_agg i_phy_irq_agg (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .evt_strobe(evt_strobe), .irq(irq), .cause_out(cause_out));

    // Behavioural reference model
    logic [15:0] m_en = '0, m_st = '0, m_rd = '0;
    logic        m_irq = 1'b0;
    logic [1:0]  m_cause = '0;

    always @(posedge clk) begin
        logic [15:0] act, nst;
        if (!rst_n) begin
            m_en = '0; m_st = '0; m_rd = '0; m_irq = 1'b0; m_cause = '0;
        end else begin
            act = m_st & m_en;
            m_irq = m_en[15] && ((act & 16'h3FFF) != 0);
            m_cause[0] = act[13] | act[11] | act[10];
            m_cause[1] = act[5] | act[6];
            if (reg_rd) begin
                if (reg_addr == 5'd25)      m_rd = m_en;
                else if (reg_addr == 5'd26) m_rd = m_st;
                else                        m_rd = '0;
            end
            nst = (reg_rd && reg_addr == 5'd26) ? 16'h0 : m_st;
            for (int i = 0; i < 16; i++)
                if (evt_strobe[i] && i != 9 && i != 12 && i < 14) nst[i] = 1'b1;
            if (reg_wr && reg_addr == 5'd25) m_en = reg_wdata & 16'hADFF;
            m_st = nst;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 irq vs model", {15'd0, irq}, {15'd0, m_irq});
            chk("R7 cause vs model", {14'd0, cause_out}, {14'd0, m_cause});
            chk("R4 rdata vs model", reg_rdata, m_rd);
        end
    end

    task automatic tick(input bit wr, input bit rd, input logic [4:0] a,
                        input logic [15:0] d, input logic [15:0] e);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; evt_strobe = e;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0; evt_strobe = '0;
    endtask

    task automatic idle();
        tick(1'b0, 1'b0, 5'd0, 16'h0, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rdata", reg_rdata, 16'h0);
        chk("R1 reset irq", {15'd0, irq}, 16'h0);
        chk("R1 reset cause", {14'd0, cause_out}, 16'h0);
        tick(0, 1, 5'd25, 0, 0);
        chk("R1 reset enable", reg_rdata, 16'h0);

        tick(1, 0, 5'd25, 16'hFFFF, 0);
        tick(0, 1, 5'd25, 0, 0);
        chk("R2 enable masked", reg_rdata, 16'hADFF);

        tick(0, 0, 0, 0, 16'hFFFF);
        idle();
        chk("R6 irq set", {15'd0, irq}, 16'h1);
        chk("R7 both causes", {14'd0, cause_out}, 16'h3);
        tick(0, 1, 5'd26, 0, 0);
        chk("R3 status masked", reg_rdata, 16'h2DFF);
        tick(0, 1, 5'd26, 0, 0);
        chk("R4 cleared by read", reg_rdata, 16'h0);

        tick(0, 0, 0, 0, 16'h0001);
        tick(0, 1, 5'd26, 0, 16'h2000);
        chk("R5 read returns older", reg_rdata, 16'h0001);
        tick(0, 1, 5'd26, 0, 0);
        chk("R5 collided event kept", reg_rdata, 16'h2000);

        tick(1, 0, 5'd25, 16'h8020, 0);
        tick(0, 0, 0, 0, 16'h0001);
        idle();
        chk("R6 disabled event no irq", {15'd0, irq}, 16'h0);
        chk("R7 disabled event no cause", {14'd0, cause_out}, 16'h0);
        tick(0, 1, 5'd26, 0, 0);
        tick(0, 0, 0, 0, 16'h0020);
        idle();
        chk("R6 enabled fifo irq", {15'd0, irq}, 16'h1);
        chk("R7 fifo cause", {14'd0, cause_out}, 16'h2);

        tick(1, 0, 5'd25, 16'h0020, 0);
        idle();
        chk("R6 global off", {15'd0, irq}, 16'h0);
        chk("R7 cause ungated", {14'd0, cause_out}, 16'h2);

        tick(1, 0, 5'd26, 16'hFFFF, 0);
        tick(1, 0, 5'd28, 16'hFFFF, 0);
        tick(0, 1, 5'd26, 0, 0);
        chk("R8 status write ignored", reg_rdata, 16'h0020);
        tick(0, 1, 5'd25, 0, 0);
        chk("R8 enable untouched", reg_rdata, 16'h0020);
        tick(0, 1, 5'd28, 0, 0);
        chk("R8 addr 28 reads 0", reg_rdata, 16'h0);

        tick(1, 0, 5'd25, 16'h8020, 16'h0020);
        idle();
        chk("R9 precondition irq", {15'd0, irq}, 16'h1);
        tick(1, 0, 5'd25, 16'h0000, 0);
        idle();
        chk("R9 irq off", {15'd0, irq}, 16'h0);
        chk("R9 cause off", {14'd0, cause_out}, 16'h0);
        tick(0, 1, 5'd26, 0, 0);

        for (int n = 0; n < 400; n++) begin
            logic [4:0] a;
            a = ($urandom % 3 == 0) ? 5'd25 : (($urandom % 2) ? 5'd26 : 5'($urandom));
            tick(($urandom % 5) == 0, ($urandom % 3) == 0, a,
                 16'($urandom), ($urandom % 2) ? (16'd1 << ($urandom % 16)) : 16'h0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule